// File: doc/BRIEF.md
# Serial Flash Continuous-Read Responder

This block is an SPI target that answers the continuous-read commands of a page-organised serial flash. The host starts a read by pulling chip-select low. It then shifts in a read opcode and a 24-bit address, plus a dummy byte for the fast opcode. From that point the target streams bytes out of its internal array for as long as the clock keeps running. The stream runs across page boundaries and past the end of the array with no idle bits. Raising chip-select ends the stream at any bit and releases the serial output.

The array holds a parameterised number of pages, each 264 bytes deep. A mode input selects how the address is read. In standard mode it is a page number followed by a byte offset inside a 264-byte page. In binary mode it is a flat byte address over 256-byte pages, which use the first 256 bytes of each physical page. A host-side write port fills the array directly by physical byte index, so tests can preload it. SPI pins are sampled on the system clock through a synchroniser. The serial clock must therefore be slower than about a tenth of the system clock.

Top module: `cfr_responder`

## Requirements
- R1: Opcode 0x0B is followed by 24 address bits and then 8 dummy bits. The output stays disabled through all of them, and bit 7 of the first data byte appears after the falling serial-clock edge that follows the last dummy bit.
- R2: Opcodes 0x03 and 0x01 take 24 address bits and no dummy bits. Bit 7 of the first data byte appears after the falling edge that follows the last address bit.
- R3: In standard mode (bin_mode = 0) the page is address bits [9 +: log2(PAGES)] and the offset is bits [8:0]. Higher address bits are ignored, and an offset of 264 or more is reduced by 264. The byte read is physical index page*264 + offset.
- R4: In binary mode (bin_mode = 1) the page is address bits [8 +: log2(PAGES)] and the offset is bits [7:0]. Higher bits are ignored, and the byte read is physical index page*264 + offset.
- R5: After the last byte of a page (offset 263 in standard mode, 255 in binary mode) the next byte comes from offset 0 of the next page, with no extra clock edges.
- R6: After the last byte of the last page the stream continues at offset 0 of page 0, with no extra clock edges.
- R7: While chip-select is high the output enable is low. A rise of chip-select in mid-byte ends the read, and the next command is decoded from scratch.
- R8: Any opcode other than 0x0B, 0x03 and 0x01 keeps the output disabled until chip-select rises.
- R9: SPI mode 0 is used. Inputs are taken on rising serial-clock edges, and the serial output changes only after falling edges. Every byte is sent most significant bit first.
- R10: A write on the preload port stores ld_data at physical index ld_idx. Reads never change the array contents.
- R11: After reset the output enable and the serial output are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bin_mode | input | 1 | 0: 264-byte page/offset addressing, 1: flat 256-byte page addressing |
| ld_we | input | 1 | Preload write strobe |
| ld_idx | input | IDX_W | Physical byte index for preload |
| ld_data | input | 8 | Preload data byte |
| spi_cs_n | input | 1 | Chip-select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data into the target |
| spi_miso | output | 1 | Serial data out of the target |
| spi_miso_oe | output | 1 | Output enable for the serial data pad (1 = driven) |

## Verification
The embedded properties check on every cycle a set of local rules. The serial output moves only after a falling-edge pulse, and the enable only turns on at one. The enable drops once chip-select is high, and stays off during the dummy phase and after an unknown opcode. The offset stays inside a page, and every step either adds one or rolls over to the next page. Only the bench can show that the right bytes come out: the address decode in both modes, the modulo-264 offset, the wrap from the last page back to page 0, recovery after an aborted read, and the array holding its contents after reads. It shows these by reading whole sequences and comparing them against values it computes itself.

// File: rtl/cfr_pkg.sv
package cfr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_SKIP
  } cfr_state_t;

  localparam logic [7:0] OPC_READ_FAST = 8'h0B;
  localparam logic [7:0] OPC_READ_SLOW = 8'h03;
  localparam logic [7:0] OPC_READ_LOWP = 8'h01;

  localparam int OPC_BITS  = 8;
  localparam int ADDR_BITS = 24;
  localparam int DUMMY_BITS = 8;

endpackage

// File: rtl/cfr_pin_sync.sv
// Brings the three SPI inputs into the clk domain and derives one-cycle
// pulses for rising and falling serial-clock edges.
module cfr_pin_sync #(
  parameter int STAGES = 2,
  localparam int CW = STAGES * 3
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic mosi_i,
  output logic cs_n_s,
  output logic mosi_s,
  output logic sck_rise,
  output logic sck_fall
);

  logic [CW-1:0] chain;
  logic [2:0]    head;
  logic          sck_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain    <= {STAGES{3'b100}};
      sck_prev <= 1'b0;
    end else begin
      chain    <= {chain[CW-4:0], cs_n_i, sck_i, mosi_i};
      sck_prev <= head[1];
    end
  end

  assign head     = chain[CW-1 -: 3];
  assign cs_n_s   = head[2];
  assign mosi_s   = head[0];
  assign sck_rise = head[1] & ~sck_prev;
  assign sck_fall = ~head[1] & sck_prev;

endmodule

// File: rtl/cfr_mem.sv
// Byte array with one write port and one registered read port.
module cfr_mem #(
  parameter int DEPTH = 2112,
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [7:0]       rdata
);

  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end

endmodule

// File: rtl/cfr_addr_gen.sv
// Holds the current page and in-page offset, decodes the loaded address
// per mode, and steps through the array with page and array roll-over.
module cfr_addr_gen #(
  parameter int PAGES    = 8,
  parameter int PAGE_STD = 264,
  localparam int PG_W     = $clog2(PAGES),
  localparam int ADDR_USE = 9 + PG_W,
  localparam int DEPTH    = PAGES * PAGE_STD,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bin_mode,
  input  logic                load,
  input  logic [ADDR_USE-1:0] load_addr,
  input  logic                step,
  output logic [IDX_W-1:0]    rd_idx
);

  logic [PG_W-1:0] page;
  logic [8:0]      off;
  logic [8:0]      raw_std;
  logic [8:0]      off_std;
  logic [8:0]      last_off;

  always_comb begin
    raw_std  = load_addr[8:0];
    off_std  = (raw_std >= 9'(PAGE_STD)) ? raw_std - 9'(PAGE_STD) : raw_std;
    last_off = bin_mode ? 9'd255 : 9'(PAGE_STD - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      page <= '0;
      off  <= '0;
    end else if (load) begin
      if (bin_mode) begin
        page <= load_addr[8 +: PG_W];
        off  <= {1'b0, load_addr[7:0]};
      end else begin
        page <= load_addr[9 +: PG_W];
        off  <= off_std;
      end
    end else if (step) begin
      if (off >= last_off) begin
        off  <= '0;
        page <= page + PG_W'(1);
      end else begin
        off <= off + 9'd1;
      end
    end
  end

  assign rd_idx = IDX_W'(page) * IDX_W'(PAGE_STD) + IDX_W'(off);

  // R3: the held offset never leaves a physical page
  a_r3_offset_in_page: assert property (@(posedge clk) disable iff (rst)
    off < 9'(PAGE_STD));

  // R5: inside a page a step advances the offset by exactly one
  a_r5_step_within_page: assert property (@(posedge clk) disable iff (rst)
    (step && !load && off < last_off) |=> (off == $past(off) + 9'd1 && page == $past(page)));

  // R5/R6: at the page end a step goes to offset 0 of the next page, modulo PAGES
  a_r6_page_roll: assert property (@(posedge clk) disable iff (rst)
    (step && !load && off >= last_off) |=> (off == 9'd0 && page == $past(page) + PG_W'(1)));

endmodule

// File: rtl/cfr_responder.sv
// SPI mode-0 target answering continuous-read opcodes from a paged array.
// PAGES must be a power of two and at least 2; PAGE_STD lies in 257..511.
module cfr_responder
  import cfr_pkg::*;
#(
  parameter int PAGES       = 8,
  parameter int PAGE_STD    = 264,
  parameter int SYNC_STAGES = 2,
  localparam int DEPTH = PAGES * PAGE_STD,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bin_mode,
  input  logic             ld_we,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [7:0]       ld_data,
  input  logic             spi_cs_n,
  input  logic             spi_sck,
  input  logic             spi_mosi,
  output logic             spi_miso,
  output logic             spi_miso_oe
);

  localparam int PG_W     = $clog2(PAGES);
  localparam int ADDR_USE = 9 + PG_W;
  localparam int SH_W     = ADDR_USE - 1;

  logic cs_n_s, mosi_s, sck_rise, sck_fall;
  logic rise_g, fall_g;

  cfr_state_t      state;
  logic [4:0]      cnt;
  logic [SH_W-1:0] sh;
  logic            need_dummy;
  logic [2:0]      bidx;
  logic [7:0]      tx;

  logic [7:0]          opc_w;
  logic [ADDR_USE-1:0] addr_w;
  logic                addr_load;
  logic                addr_step;
  logic [IDX_W-1:0]    rd_idx;
  logic [7:0]          rd_q;

  cfr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .cs_n_i   (spi_cs_n),
    .sck_i    (spi_sck),
    .mosi_i   (spi_mosi),
    .cs_n_s   (cs_n_s),
    .mosi_s   (mosi_s),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall)
  );

  assign rise_g = sck_rise & ~cs_n_s;
  assign fall_g = sck_fall & ~cs_n_s;

  assign opc_w     = {sh[6:0], mosi_s};
  assign addr_w    = {sh, mosi_s};
  assign addr_load = rise_g && (state == ST_ADDR) && (cnt == 5'(ADDR_BITS - 1));
  assign addr_step = fall_g && (state == ST_DATA) && (bidx == 3'd0);

  cfr_addr_gen #(.PAGES(PAGES), .PAGE_STD(PAGE_STD)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .bin_mode  (bin_mode),
    .load      (addr_load),
    .load_addr (addr_w),
    .step      (addr_step),
    .rd_idx    (rd_idx)
  );

  cfr_mem #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
    .clk   (clk),
    .we    (ld_we),
    .waddr (ld_idx),
    .wdata (ld_data),
    .raddr (rd_idx),
    .rdata (rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      sh          <= '0;
      need_dummy  <= 1'b0;
      bidx        <= '0;
      tx          <= '0;
      spi_miso    <= 1'b0;
      spi_miso_oe <= 1'b0;
    end else if (cs_n_s) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      bidx        <= '0;
      spi_miso_oe <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          state <= ST_OPC;
          cnt   <= '0;
          bidx  <= '0;
        end
        ST_OPC: if (rise_g) begin
          sh <= {sh[SH_W-2:0], mosi_s};
          if (cnt == 5'(OPC_BITS - 1)) begin
            cnt <= '0;
            case (opc_w)
              OPC_READ_FAST: begin
                state      <= ST_ADDR;
                need_dummy <= 1'b1;
              end
              OPC_READ_SLOW, OPC_READ_LOWP: begin
                state      <= ST_ADDR;
                need_dummy <= 1'b0;
              end
              default: state <= ST_SKIP;
            endcase
          end else begin
            cnt <= cnt + 5'd1;
          end
        end
        ST_ADDR: if (rise_g) begin
          sh <= {sh[SH_W-2:0], mosi_s};
          if (cnt == 5'(ADDR_BITS - 1)) begin
            cnt   <= '0;
            state <= need_dummy ? ST_DUMMY : ST_DATA;
          end else begin
            cnt <= cnt + 5'd1;
          end
        end
        ST_DUMMY: if (rise_g) begin
          if (cnt == 5'(DUMMY_BITS - 1)) begin
            cnt   <= '0;
            state <= ST_DATA;
          end else begin
            cnt <= cnt + 5'd1;
          end
        end
        ST_DATA: if (fall_g) begin
          spi_miso_oe <= 1'b1;
          if (bidx == 3'd0) begin
            tx       <= rd_q;
            spi_miso <= rd_q[7];
          end else begin
            spi_miso <= tx[3'd7 - bidx];
          end
          bidx <= bidx + 3'd1;
        end
        ST_SKIP: ;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: a deasserted chip-select releases the output on the next cycle
  a_r7_release_on_cs: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !spi_miso_oe);

  // R9: serial output moves only after a falling serial-clock edge
  a_r9_miso_on_fall: assert property (@(posedge clk) disable iff (rst)
    !sck_fall |=> $stable(spi_miso));

  // R9: output enable is only switched on by a falling edge
  a_r9_oe_on_fall: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_miso_oe) |-> $past(sck_fall));

  // R8: an unknown opcode keeps the pad released
  a_r8_skip_silent: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |-> !spi_miso_oe);

  // R1: no data is driven during the dummy byte
  a_r1_dummy_silent: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DUMMY) |-> !spi_miso_oe);

endmodule

// File: tb/cfr_responder_test.sv
`timescale 1ns/1ps
module cfr_responder_test;

  localparam int PAGES = 4;
  localparam int PSTD  = 264;
  localparam int DEPTH = PAGES * PSTD;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int H     = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             bin_mode = 1'b0;
  logic             ld_we = 1'b0;
  logic [IDX_W-1:0] ld_idx = '0;
  logic [7:0]       ld_data = '0;
  logic             spi_cs_n = 1'b1;
  logic             spi_sck = 1'b0;
  logic             spi_mosi = 1'b0;
  logic             spi_miso;
  logic             spi_miso_oe;

  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;
  logic [7:0] model [DEPTH];

  always #10 clk = ~clk;

  cfr_responder #(.PAGES(PAGES), .PAGE_STD(PSTD)) uut (
    .clk(clk), .rst(rst), .bin_mode(bin_mode),
    .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11 + (i >> 5)) & 255);
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic spi_bit(input logic mo, output logic mi, output logic oe, output logic st);
    spi_mosi = mo;
    wait_clk(H);
    mi = spi_miso;
    oe = spi_miso_oe;
    spi_sck = 1'b1;
    wait_clk(H - 1);
    st = (spi_miso == mi);
    wait_clk(1);
    spi_sck = 1'b0;
  endtask

  task automatic header(input logic [7:0] op, input logic [23:0] a, input bit dummy, output bit quiet);
    logic mi, oe, st;
    quiet = 1'b1;
    spi_cs_n = 1'b0;
    wait_clk(H);
    for (int k = 7; k >= 0; k--) begin spi_bit(op[k], mi, oe, st); if (oe) quiet = 1'b0; end
    for (int k = 23; k >= 0; k--) begin spi_bit(a[k], mi, oe, st); if (oe) quiet = 1'b0; end
    if (dummy)
      for (int k = 0; k < 8; k++) begin spi_bit(1'b1, mi, oe, st); if (oe) quiet = 1'b0; end
  endtask

  task automatic get_byte(output logic [7:0] b, output bit ok);
    logic mi, oe, st;
    ok = 1'b1;
    for (int k = 7; k >= 0; k--) begin
      spi_bit(1'b0, mi, oe, st);
      b[k] = mi;
      if (!oe || !st) ok = 1'b0;
    end
  endtask

  task automatic end_cmd();
    spi_cs_n = 1'b1;
    wait_clk(2 * H);
  endtask

  task automatic read_check(input bit bm, input logic [7:0] op, input logic [23:0] a,
                            input int n, input string req);
    int pg, of, idx;
    bit q, ok;
    logic [7:0] b;
    bin_mode = bm;
    wait_clk(2);
    if (bm) begin
      pg = (int'(a) >> 8) % PAGES;
      of = int'(a) & 255;
    end else begin
      pg = (int'(a) >> 9) % PAGES;
      of = int'(a) & 511;
      if (of >= PSTD) of -= PSTD;
    end
    header(op, a, (op == 8'h0B), q);
    check(q, {req, " output idle during header"}, 0, 0);
    for (int k = 0; k < n; k++) begin
      idx = pg * PSTD + of;
      get_byte(b, ok);
      check(ok && (b == model[idx]), req, int'(b), int'(model[idx]));
      of++;
      if (of == (bm ? 256 : PSTD)) begin
        of = 0;
        pg = (pg + 1) % PAGES;
      end
    end
    end_cmd();
  endtask

  initial begin
    bit quiet;
    logic mi, oe, st;
    logic [7:0] b;
    bit ok;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    // R11: reset state of the serial pad
    check(spi_miso_oe == 1'b0 && spi_miso == 1'b0, "R11", {spi_miso_oe, spi_miso}, 0);

    // R10: preload the whole array through the host port
    for (int i = 0; i < DEPTH; i++) begin
      model[i] = pat(i);
      ld_we = 1'b1; ld_idx = IDX_W'(i); ld_data = pat(i);
      wait_clk(1);
    end
    ld_we = 1'b0;
    wait_clk(2);

    // R2: slow and low-power opcodes, no dummy byte
    read_check(1'b0, 8'h03, 24'h000000, 24, "R2");
    // R5: page crossing in standard mode (page 1 offset 260)
    read_check(1'b0, 8'h01, {11'd1, 9'd260}, 10, "R5");
    // R1/R6: fast opcode with dummy, last page wraps to page 0
    read_check(1'b0, 8'h0B, {11'd3, 9'd258}, 12, "R1 R6");
    // R3: high bits ignored, page field beyond PAGES, offset 300 -> 36
    read_check(1'b0, 8'h03, {4'hF, 11'd14, 9'd300}, 4, "R3");
    // R4: binary mode crossing 256-byte page
    read_check(1'b1, 8'h03, 24'h0000FA, 10, "R4");
    // R4/R6: binary mode, upper bits ignored, wrap from last page
    read_check(1'b1, 8'h0B, 24'hABC3FC, 8, "R4 R6");

    // R8: unknown opcode keeps the output released
    bin_mode = 1'b0;
    header(8'h55, 24'h000010, 1'b0, quiet);
    for (int k = 0; k < 4; k++) begin
      get_byte(b, ok);
      check(spi_miso_oe == 1'b0 && !ok, "R8", int'(spi_miso_oe), 0);
    end
    end_cmd();

    // R7: abort in mid-byte, then a fresh command decodes correctly
    header(8'h03, 24'h000000, 1'b0, quiet);
    for (int k = 0; k < 3; k++) spi_bit(1'b0, mi, oe, st);
    check(spi_miso_oe == 1'b1, "R7 data active before abort", int'(spi_miso_oe), 1);
    spi_cs_n = 1'b1;
    wait_clk(6);
    check(spi_miso_oe == 1'b0, "R7", int'(spi_miso_oe), 0);
    wait_clk(2 * H);
    read_check(1'b0, 8'h0B, {11'd2, 9'd5}, 3, "R7");

    // R9: MSB-first order and stable output while clock high, checked in a mixed pattern
    read_check(1'b0, 8'h01, {11'd0, 9'd263}, 3, "R9");

    // R10: single preload write is visible
    ld_we = 1'b1; ld_idx = IDX_W'(5); ld_data = 8'h5A; model[5] = 8'h5A;
    wait_clk(1);
    ld_we = 1'b0;
    wait_clk(2);
    read_check(1'b0, 8'h03, 24'h000005, 1, "R10");

    // R5 R6 R10: sweep the whole array and past its end; contents unchanged by reads
    read_check(1'b0, 8'h03, 24'h000000, DEPTH + 8, "R10 sweep");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule